// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the control address of a microprogrammed control unit and works out, every cycle, where the following microinstruction comes from. The control store is a combinational ROM that sits outside the block. It is read through the control address output. The select, condition-index and branch-address fields of the word it returns come back into the sequencer within the same cycle. The sequencer chooses between four next-address sources:

- stepping to the following address;
- a branch that depends on a selected external condition line;
- a branch that is always taken;
- an address supplied from outside, for example a dispatch address derived from an opcode.

The control address register is the only clocked element. Each rising clock edge retires the current control word and loads its successor, so there is no pipeline register between the ROM and the datapath. A synchronous start input, and the asynchronous reset, bring the register to the fixed initial address so that a new control routine can begin.

Top module: `mseq_sequencer`

## Requirements
- R1: While the active-low reset `rst_n` is low, the control address `car` is the initial address (parameter `INIT_ADDR`, default 0). It takes that value without waiting for a clock edge.
- R2: With `start` low and `sel` = 2'b00 (step), `car` becomes the old `car` plus one after the rising edge.
- R3: Stepping from the all-ones address gives address 0. The count wraps modulo 2^`ADDR_W`.
- R4: With `start` low and `sel` = 2'b01 (conditional branch), if the selected condition bit is 1, `car` becomes `br_addr` after the edge.
- R5: With `start` low and `sel` = 2'b01, if the selected condition bit is 0, `car` becomes the old `car` plus one after the edge.
- R6: With `start` low and `sel` = 2'b10 (jump), `car` becomes `br_addr` after the edge, whatever the condition inputs hold.
- R7: With `start` low and `sel` = 2'b11 (dispatch), `car` becomes `map_addr` after the edge.
- R8: With `start` high, `car` becomes `INIT_ADDR` after the edge. This overrides every select code and every other input.
- R9: The condition tested by a conditional branch is bit `cond_idx` of `cond_in`. The other bits of `cond_in` have no effect on the result. An index at or beyond `COND_W` reads as false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-phase clock; the address register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the initial address |
| start | input | 1 | Synchronous load of the initial address |
| sel | input | 2 | Next-address source field of the current microinstruction |
| cond_idx | input | IDX_W | Condition-select field of the current microinstruction |
| br_addr | input | ADDR_W | Branch-address field of the current microinstruction |
| cond_in | input | COND_W | External condition lines |
| map_addr | input | ADDR_W | Externally supplied dispatch address |
| car | output | ADDR_W | Control address driving the control-store ROM |

## Verification
The bench forces every starting address. From each one it applies every select code, every condition pattern and every condition index. This covers the fall-through of a conditional branch whose bit is clear, which a faulty design would branch on anyway or would hold its address instead of stepping. It also covers condition patterns in which only a bit that is not selected is set; a design that reduced the whole vector, or used the wrong index, would branch on these. The step from the top address is checked for a wrap to zero rather than a saturation. The start and reset tests confirm that the initial address wins over a jump or a dispatch, and that reset acts at once, without a clock edge.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   // Next-address source codes carried in the microinstruction select field
   typedef enum logic [1:0] {
      SRC_STEP = 2'b00,
      SRC_CJMP = 2'b01,
      SRC_JMP  = 2'b10,
      SRC_MAP  = 2'b11
   } src_sel_e;

endpackage

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux #(
   parameter int COND_W = 4,
   parameter int IDX_W  = (COND_W > 1) ? $clog2(COND_W) : 1
) (
   input  logic [COND_W-1:0] cond_in,
   input  logic [IDX_W-1:0]  cond_idx,
   output logic              cond_hit
);

   initial begin
      if (COND_W < 1)
         $error("mseq_cond_mux: COND_W must be at least 1");
      if ((1 << IDX_W) < COND_W)
         $error("mseq_cond_mux: IDX_W too narrow for COND_W");
   end

   generate
      if (COND_W == 1) begin : g_single
         // one line only: any non-zero index is out of range and reads false
         assign cond_hit = cond_in[0] & (cond_idx == '0);
      end else begin : g_multi
         always_comb begin
            if (int'(cond_idx) < COND_W)
               cond_hit = cond_in[cond_idx];
            else
               cond_hit = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
   import mseq_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter logic [ADDR_W-1:0] INIT_A = '0
) (
   input  logic [ADDR_W-1:0] car,
   input  logic              start,
   input  logic [1:0]        sel,
   input  logic              cond_hit,
   input  logic [ADDR_W-1:0] br_addr,
   input  logic [ADDR_W-1:0] map_addr,
   output logic [ADDR_W-1:0] nxt
);

   logic [ADDR_W-1:0] step_addr;
   src_sel_e          src;

   // modulo 2^ADDR_W increment: the top address wraps to zero
   assign step_addr = car + ADDR_W'(1);
   assign src       = src_sel_e'(sel);

   always_comb begin
      if (start) begin
         nxt = INIT_A;
      end else begin
         unique case (src)
            SRC_STEP: nxt = step_addr;
            SRC_CJMP: nxt = cond_hit ? br_addr : step_addr;
            SRC_JMP:  nxt = br_addr;
            SRC_MAP:  nxt = map_addr;
            default:  nxt = step_addr;
         endcase
      end
   end

endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
   import mseq_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int COND_W    = 4,
   parameter int INIT_ADDR = 0,
   parameter int IDX_W     = (COND_W > 1) ? $clog2(COND_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        sel,
   input  logic [IDX_W-1:0]  cond_idx,
   input  logic [ADDR_W-1:0] br_addr,
   input  logic [COND_W-1:0] cond_in,
   input  logic [ADDR_W-1:0] map_addr,
   output logic [ADDR_W-1:0] car
);

   localparam logic [ADDR_W-1:0] INIT_A = ADDR_W'(INIT_ADDR);
   localparam logic [ADDR_W-1:0] TOP_A  = '1;

   initial begin
      if (ADDR_W < 2 || ADDR_W > 30)
         $error("mseq_sequencer: ADDR_W out of range");
      if (INIT_ADDR < 0 || INIT_ADDR >= (1 << ADDR_W))
         $error("mseq_sequencer: INIT_ADDR does not fit ADDR_W");
   end

   logic              cond_hit;
   logic [ADDR_W-1:0] nxt;
   logic [ADDR_W-1:0] car_q;

   mseq_cond_mux #(
      .COND_W (COND_W),
      .IDX_W  (IDX_W)
   ) u_cond (
      .cond_in  (cond_in),
      .cond_idx (cond_idx),
      .cond_hit (cond_hit)
   );

   mseq_next_addr #(
      .ADDR_W (ADDR_W),
      .INIT_A (INIT_A)
   ) u_next (
      .car      (car_q),
      .start    (start),
      .sel      (sel),
      .cond_hit (cond_hit),
      .br_addr  (br_addr),
      .map_addr (map_addr),
      .nxt      (nxt)
   );

   // the only clocked element: the control address register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         car_q <= INIT_A;
      else
         car_q <= nxt;
   end

   assign car = car_q;

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && sel == 2'b00) |=> (car == $past(car) + ADDR_W'(1)));

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && sel == 2'b00 && car == TOP_A) |=> (car == '0));

   p_cjmp_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && sel == 2'b01 && cond_hit) |=> (car == $past(br_addr)));

   p_cjmp_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && sel == 2'b01 && !cond_hit) |=> (car == $past(car) + ADDR_W'(1)));

   p_jmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && sel == 2'b10) |=> (car == $past(br_addr)));

   p_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && sel == 2'b11) |=> (car == $past(map_addr)));

   p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (car == INIT_A));

   p_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cond_idx) >= COND_W) |-> !cond_hit);

endmodule

// File: tb/mseq_sequencer_bench.sv
`timescale 1ns/100ps
module mseq_sequencer_bench;

   localparam int AW = 4;
   localparam int CW = 4;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    sel = 2'b00;
   logic [IW-1:0] cond_idx = '0;
   logic [AW-1:0] br_addr = '0;
   logic [CW-1:0] cond_in = '0;
   logic [AW-1:0] map_addr = '0;
   logic [AW-1:0] car;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   mseq_sequencer #(
      .ADDR_W    (AW),
      .COND_W    (CW),
      .INIT_ADDR (0)
   ) u_mseq_sequencer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .sel      (sel),
      .cond_idx (cond_idx),
      .br_addr  (br_addr),
      .cond_in  (cond_in),
      .map_addr (map_addr),
      .car      (car)
   );

   task automatic check(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: car=%0d expected %0d", req, got, exp);
      end
   endtask

   // apply one microinstruction at a falling edge, let one rising edge pass
   task automatic apply(input logic st, input logic [1:0] s, input logic [IW-1:0] ci,
                        input logic [AW-1:0] ba, input logic [CW-1:0] cv,
                        input logic [AW-1:0] ma);
      start    = st;
      sel      = s;
      cond_idx = ci;
      br_addr  = ba;
      cond_in  = cv;
      map_addr = ma;
      @(negedge clk);
   endtask

   // place the address register at a by an unconditional jump
   task automatic place(input logic [AW-1:0] a);
      apply(1'b0, 2'b10, '0, a, '0, '0);
   endtask

   initial begin
      // R1: held in reset with a jump request present
      br_addr = 4'd9;
      sel     = 2'b10;
      repeat (3) @(negedge clk);
      check("R1 reset value", car, 4'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 first jump after reset", car, 4'd9);

      // exhaustive sweep: start address x select x condition pattern x index
      for (int a = 0; a < 16; a++) begin
         for (int s = 0; s < 4; s++) begin
            for (int cv = 0; cv < 16; cv++) begin
               for (int ci = 0; ci < 4; ci++) begin
                  logic [AW-1:0] ba;
                  logic [AW-1:0] ma;
                  logic [AW-1:0] inc;
                  logic [AW-1:0] exp;
                  logic          bit_set;
                  ba      = AW'((a * 7 + cv + 3) % 16);
                  ma      = AW'((a * 5 + ci + 9) % 16);
                  inc     = AW'((a + 1) % 16);
                  bit_set = cv[ci];
                  place(AW'(a));
                  apply(1'b0, 2'(s), IW'(ci), ba, CW'(cv), ma);
                  case (s)
                     0: begin
                        exp = inc;
                        if (a == 15) check("R3 wrap from top", car, exp);
                        else         check("R2 step", car, exp);
                     end
                     1: begin
                        exp = bit_set ? ba : inc;
                        if (bit_set) check("R4 conditional taken, R9 selected bit", car, exp);
                        else         check("R5 conditional fall-through, R9 other bits ignored", car, exp);
                     end
                     2: begin
                        exp = ba;
                        check("R6 jump ignores conditions", car, exp);
                     end
                     default: begin
                        exp = ma;
                        check("R7 dispatch", car, exp);
                     end
                  endcase
               end
            end
         end
      end

      // R8: start overrides every select code, with all conditions set
      for (int a = 1; a < 16; a += 3) begin
         for (int s = 0; s < 4; s++) begin
            place(AW'(a));
            apply(1'b1, 2'(s), 2'd0, 4'd11, 4'hF, 4'd13);
            check("R8 start wins", car, 4'd0);
         end
      end

      // R1: asynchronous reset in mid-run, observed before any clock edge
      place(4'd12);
      check("R6 place before reset", car, 4'd12);
      apply(1'b0, 2'b11, 2'd0, 4'd5, 4'h0, 4'd7);
      check("R7 dispatch before reset", car, 4'd7);
      #0.5 rst_n = 1'b0;
      #0.5;
      check("R1 async reset", car, 4'd0);
      @(negedge clk);
      check("R1 held in reset", car, 4'd0);
      rst_n = 1'b1;
      apply(1'b0, 2'b00, 2'd0, 4'd0, 4'h0, 4'd0);
      check("R2 step after reset", car, 4'd1);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: run did not finish, car=%0d expected end of test", car);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule